// File: doc/BRIEF.md
# Unlock-Sequence Flash Command Decoder

This block sits behind the bus interface of a byte-wide flash array. It takes host write cycles that have already been captured into the clock domain: an address, a data byte and a one-cycle write strobe. It decides whether they form a valid command. A command opens with a fixed two-write unlock prefix. A setup code follows, and for erase-class commands a second prefix and a final code. When a sequence completes, the decoder raises a one-cycle start request for the job it names and holds the target address and data for the job engine.

The decoder also owns the identification mode. While that mode is on, the read path takes its byte from a small map: the maker code, the device code and the boot-lockout flag, chosen by the low read-address bits. A write that breaks the expected sequence abandons the sequence and returns the decoder to array reads. While the job engine reports busy, every write is dropped.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `id_mode` is 0 and all four start outputs are 0.
- R2: The unlock prefix is AA written to address 5555 (hex), then 55 written to 2AAA. Only address bits 14..0 take part in every command-address comparison. Bits 17..15 are ignored.
- R3: Prefix, then A0 at 5555, then one write to any address. That last write makes `start_prog` high for exactly the next cycle, with `job_addr`/`job_data` holding that write's address and data.
- R4: Prefix, 80 at 5555, prefix, then 10 at 5555 makes `start_chip_erase` high for one cycle.
- R5: The same six-write form ending with 30 at any address makes `start_sect_erase` high for one cycle, with `job_addr` equal to that address.
- R6: The same six-write form ending with 40 at 5555 makes `start_lock_set` high for one cycle.
- R7: Prefix, then 90 at 5555, sets `id_mode` to 1 in the cycle after the write. Writes that match the next step of a sequence leave `id_mode` unchanged.
- R8: `id_mode` returns to 0 after prefix + F0 at 5555, or after a single F0 write to any address.
- R9: A write that does not match the expected step aborts the sequence, issues no start and clears `id_mode`. No other setup or final code starts anything.
- R10: A mismatching write that is itself AA at 5555 is taken as the first prefix step of a new sequence.
- R11: While `busy` is 1, writes change neither the sequence position nor `id_mode`, and no start is issued.
- R12: `id_rd_data` by `rd_ofs`: 0 gives DA, 1 gives 0B, 2 gives `lock_state` on bit 0 with bits 7..1 zero, 3 gives 00.
- R13: At most one start output is high in any cycle, and none is high two cycles running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle host write strobe |
| wr_addr | input | 18 | Host write address |
| wr_data | input | 8 | Host write data |
| busy | input | 1 | Program or erase job running |
| rd_ofs | input | 2 | Low read-address bits for the ID map |
| lock_state | input | 1 | Current boot-lockout flag |
| id_mode | output | 1 | 1 selects ID reads, 0 array reads |
| id_rd_data | output | 8 | ID map byte |
| start_prog | output | 1 | Byte program start pulse |
| start_chip_erase | output | 1 | Chip erase start pulse |
| start_sect_erase | output | 1 | Sector erase start pulse |
| start_lock_set | output | 1 | Lockout set start pulse |
| job_addr | output | 18 | Target address of the last job |
| job_data | output | 8 | Program data of the last job |

## Verification
The bench sweeps all 256 values of the setup byte and all 256 values of the final erase byte. A decoder that accepts a near-miss code, or that remains armed after a wrong code, would then start a job where none is due. Prefixes with the upper address bits set, and with bit 14 cleared, catch a comparator that uses too many or too few bits. A restart sequence (AA, AA, 55, 90) and busy writes placed inside a sequence check the recovery and ignore rules. A design that got either rule wrong would lose a valid command or act on a write it should have dropped. The ID-map reads and both exit forms are checked with the lockout flag at both values.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] KEY_A_DATA   = 8'hAA;
  localparam logic [7:0] KEY_B_DATA   = 8'h55;
  localparam logic [7:0] OP_PROG      = 8'hA0;
  localparam logic [7:0] OP_ERS_SETUP = 8'h80;
  localparam logic [7:0] OP_CHIP      = 8'h10;
  localparam logic [7:0] OP_SECT      = 8'h30;
  localparam logic [7:0] OP_LOCK      = 8'h40;
  localparam logic [7:0] OP_ID_ON     = 8'h90;
  localparam logic [7:0] OP_ID_OFF    = 8'hF0;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_KEY1, SQ_KEY2, SQ_PROG, SQ_ERS, SQ_ERS_K1, SQ_ERS_K2
  } seq_t;

  typedef enum logic [2:0] {
    JOB_NONE, JOB_PROG, JOB_CHIP, JOB_SECT, JOB_LOCK
  } job_t;
endpackage

// File: rtl/cmd_key_match.sv
module cmd_key_match #(
  parameter int CMP_W = 15,
  parameter logic [CMP_W-1:0] KEY_A_ADDR = 15'h5555,
  parameter logic [CMP_W-1:0] KEY_B_ADDR = 15'h2AAA
) (
  input  logic [CMP_W-1:0] addr,
  input  logic [7:0]       data,
  output logic             hit_key_a,
  output logic             hit_key_b,
  output logic             at_cmd_addr
);
  import flash_cmd_pkg::*;

  always_comb begin
    at_cmd_addr = (addr == KEY_A_ADDR);
    hit_key_a   = at_cmd_addr && (data == KEY_A_DATA);
    hit_key_b   = (addr == KEY_B_ADDR) && (data == KEY_B_DATA);
  end
endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_stb,
  input  logic                busy,
  input  logic [7:0]          wr_data,
  input  logic                hit_key_a,
  input  logic                hit_key_b,
  input  logic                at_cmd_addr,
  output flash_cmd_pkg::job_t job_now,
  output flash_cmd_pkg::job_t job_q,
  output logic                id_mode
);
  import flash_cmd_pkg::*;

  seq_t seq_q, seq_nxt;
  logic id_nxt;
  logic accept;

  assign accept = wr_stb && !busy;

  always_comb begin
    seq_nxt = seq_q;
    id_nxt  = id_mode;
    job_now = JOB_NONE;
    if (accept) begin
      // mismatch default: back to read mode, but AA@5555 restarts a sequence
      seq_nxt = hit_key_a ? SQ_KEY1 : SQ_IDLE;
      id_nxt  = 1'b0;
      unique case (seq_q)
        SQ_IDLE: begin
          if (hit_key_a) id_nxt = id_mode;
        end
        SQ_KEY1: begin
          if (hit_key_b) begin
            seq_nxt = SQ_KEY2;
            id_nxt  = id_mode;
          end
        end
        SQ_KEY2: begin
          if (at_cmd_addr) begin
            if (wr_data == OP_PROG) begin
              seq_nxt = SQ_PROG;
              id_nxt  = id_mode;
            end else if (wr_data == OP_ERS_SETUP) begin
              seq_nxt = SQ_ERS;
              id_nxt  = id_mode;
            end else if (wr_data == OP_ID_ON) begin
              seq_nxt = SQ_IDLE;
              id_nxt  = 1'b1;
            end else if (wr_data == OP_ID_OFF) begin
              seq_nxt = SQ_IDLE;
            end
          end
        end
        SQ_PROG: begin
          seq_nxt = SQ_IDLE;
          id_nxt  = id_mode;
          job_now = JOB_PROG;
        end
        SQ_ERS: begin
          if (hit_key_a) begin
            seq_nxt = SQ_ERS_K1;
            id_nxt  = id_mode;
          end
        end
        SQ_ERS_K1: begin
          if (hit_key_b) begin
            seq_nxt = SQ_ERS_K2;
            id_nxt  = id_mode;
          end
        end
        SQ_ERS_K2: begin
          if (wr_data == OP_SECT) begin
            job_now = JOB_SECT;
          end else if (at_cmd_addr && wr_data == OP_CHIP) begin
            job_now = JOB_CHIP;
          end else if (at_cmd_addr && wr_data == OP_LOCK) begin
            job_now = JOB_LOCK;
          end
          if (job_now != JOB_NONE) begin
            seq_nxt = SQ_IDLE;
            id_nxt  = id_mode;
          end
        end
        default: begin
          seq_nxt = SQ_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q   <= SQ_IDLE;
      id_mode <= 1'b0;
      job_q   <= JOB_NONE;
    end else begin
      seq_q   <= seq_nxt;
      id_mode <= id_nxt;
      job_q   <= job_now;
    end
  end
endmodule

// File: rtl/id_read_map.sv
module id_read_map #(
  parameter int         OFS_W    = 2,
  parameter logic [7:0] MFR_CODE = 8'hDA,
  parameter logic [7:0] DEV_CODE = 8'h0B
) (
  input  logic [OFS_W-1:0] rd_ofs,
  input  logic             lock_state,
  output logic [7:0]       id_rd_data
);
  always_comb begin
    id_rd_data = 8'h00;
    if (rd_ofs == OFS_W'(0))      id_rd_data = MFR_CODE;
    else if (rd_ofs == OFS_W'(1)) id_rd_data = DEV_CODE;
    else if (rd_ofs == OFS_W'(2)) id_rd_data = {7'b0, lock_state};
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int         ADDR_W   = 18,
  parameter int         CMP_W    = 15,
  parameter int         OFS_W    = 2,
  parameter logic [7:0] MFR_CODE = 8'hDA,
  parameter logic [7:0] DEV_CODE = 8'h0B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic [OFS_W-1:0]  rd_ofs,
  input  logic              lock_state,
  output logic              id_mode,
  output logic [7:0]        id_rd_data,
  output logic              start_prog,
  output logic              start_chip_erase,
  output logic              start_sect_erase,
  output logic              start_lock_set,
  output logic [ADDR_W-1:0] job_addr,
  output logic [7:0]        job_data
);
  import flash_cmd_pkg::*;

  logic hit_key_a, hit_key_b, at_cmd_addr;
  job_t job_now, job_q;
  logic job_load;

  cmd_key_match #(.CMP_W(CMP_W)) u_match (
    .addr       (wr_addr[CMP_W-1:0]),
    .data       (wr_data),
    .hit_key_a  (hit_key_a),
    .hit_key_b  (hit_key_b),
    .at_cmd_addr(at_cmd_addr)
  );

  cmd_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .busy       (busy),
    .wr_data    (wr_data),
    .hit_key_a  (hit_key_a),
    .hit_key_b  (hit_key_b),
    .at_cmd_addr(at_cmd_addr),
    .job_now    (job_now),
    .job_q      (job_q),
    .id_mode    (id_mode)
  );

  id_read_map #(.OFS_W(OFS_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_idmap (
    .rd_ofs    (rd_ofs),
    .lock_state(lock_state),
    .id_rd_data(id_rd_data)
  );

  assign job_load = (job_now != JOB_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      job_addr <= '0;
      job_data <= '0;
    end else if (job_load) begin
      job_addr <= wr_addr;
      job_data <= wr_data;
    end
  end

  assign start_prog       = (job_q == JOB_PROG);
  assign start_chip_erase = (job_q == JOB_CHIP);
  assign start_sect_erase = (job_q == JOB_SECT);
  assign start_lock_set   = (job_q == JOB_LOCK);
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              busy,
  input logic              id_mode,
  input logic              start_prog,
  input logic              start_chip_erase,
  input logic              start_sect_erase,
  input logic              start_lock_set,
  input logic [ADDR_W-1:0] job_addr,
  input logic [7:0]        job_data
);
  logic [3:0] starts;
  assign starts = {start_lock_set, start_sect_erase, start_chip_erase, start_prog};

  a_r13_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(starts));
  a_r13_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (starts != 4'b0) |=> (starts == 4'b0));
  a_r3_prog_capture: assert property (@(posedge clk) disable iff (!rst_n)
    start_prog |-> (job_addr == $past(wr_addr) && job_data == $past(wr_data) && $past(wr_stb)));
  a_r4_chip_code: assert property (@(posedge clk) disable iff (!rst_n)
    start_chip_erase |-> ($past(wr_data) == 8'h10));
  a_r5_sect_addr: assert property (@(posedge clk) disable iff (!rst_n)
    start_sect_erase |-> ($past(wr_data) == 8'h30 && job_addr == $past(wr_addr)));
  a_r6_lock_code: assert property (@(posedge clk) disable iff (!rst_n)
    start_lock_set |-> ($past(wr_data) == 8'h40));
  a_r7_id_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> ($past(wr_stb) && $past(wr_data) == 8'h90));
  a_r11_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_stb) |=> (starts == 4'b0 && $stable(id_mode)));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
  .busy(busy), .id_mode(id_mode), .start_prog(start_prog),
  .start_chip_erase(start_chip_erase), .start_sect_erase(start_sect_erase),
  .start_lock_set(start_lock_set), .job_addr(job_addr), .job_data(job_data)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [17:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy = 1'b0;
  logic [1:0]  rd_ofs = '0;
  logic        lock_state = 1'b0;
  logic        id_mode;
  logic [7:0]  id_rd_data;
  logic        start_prog, start_chip_erase, start_sect_erase, start_lock_set;
  logic [17:0] job_addr;
  logic [7:0]  job_data;
  logic [3:0]  st;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  flash_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .rd_ofs(rd_ofs), .lock_state(lock_state), .id_mode(id_mode),
    .id_rd_data(id_rd_data), .start_prog(start_prog), .start_chip_erase(start_chip_erase),
    .start_sect_erase(start_sect_erase), .start_lock_set(start_lock_set),
    .job_addr(job_addr), .job_data(job_data)
  );

  assign st = {start_lock_set, start_sect_erase, start_chip_erase, start_prog};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one write; on return the registered result of that write is visible
  task automatic wr(input logic [17:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic prefix();
    wr(18'h05555, 8'hAA);
    wr(18'h02AAA, 8'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 id_mode after reset", 32'(id_mode), 0);
    chk("R1 starts after reset", 32'(st), 0);

    // R3 / R7 / R9: sweep every setup byte
    for (int b = 0; b < 256; b++) begin
      logic [7:0] bb;
      bb = 8'(b);
      wr(18'h00000, 8'hF0);
      prefix();
      wr(18'h05555, bb);
      chk((bb == 8'h90) ? "R7 id entry" : "R9 setup byte id", 32'(id_mode), (bb == 8'h90) ? 1 : 0);
      wr(18'h12345 ^ 18'(b), 8'h5A ^ bb);
      chk((bb == 8'hA0) ? "R3 program start" : "R9 no start", 32'(st), (bb == 8'hA0) ? 1 : 0);
      if (bb == 8'hA0) begin
        chk("R3 job_addr", 32'(job_addr), 32'(18'h12345 ^ 18'(b)));
        chk("R3 job_data", 32'(job_data), 32'(8'h5A ^ bb));
        @(negedge clk);
        chk("R13 pulse one cycle", 32'(st), 0);
      end
    end

    // R4 / R5 / R6 / R9: sweep every final erase byte
    for (int b = 0; b < 256; b++) begin
      logic [7:0] bb;
      logic [3:0] exp;
      bb = 8'(b);
      exp = (bb == 8'h10) ? 4'b0010 : (bb == 8'h30) ? 4'b0100 : (bb == 8'h40) ? 4'b1000 : 4'b0000;
      wr(18'h00000, 8'hF0);
      prefix();
      wr(18'h05555, 8'h80);
      prefix();
      wr(18'h05555, bb);
      chk((bb == 8'h10) ? "R4 chip erase" : (bb == 8'h30) ? "R5 sector erase" :
          (bb == 8'h40) ? "R6 lock set" : "R9 final byte", 32'(st), 32'(exp));
      if (exp != 4'b0) begin
        @(negedge clk);
        chk("R13 erase pulse one cycle", 32'(st), 0);
      end
    end

    // R5: sector address captured from any location
    prefix(); wr(18'h05555, 8'h80); prefix();
    wr(18'h3A123, 8'h30);
    chk("R5 sector start", 32'(st), 4'b0100);
    chk("R5 sector address", 32'(job_addr), 32'(18'h3A123));
    // R5 negative: 10 away from 5555 is not a chip erase
    prefix(); wr(18'h05555, 8'h80); prefix();
    wr(18'h01234, 8'h10);
    chk("R4 chip code off address", 32'(st), 0);

    // R2: upper address bits ignored
    wr(18'h3D555, 8'hAA); wr(18'h1AAAA, 8'h55); wr(18'h25555, 8'hA0);
    wr(18'h00042, 8'h24);
    chk("R2 upper bits ignored", 32'(st), 1);
    // R2: bit 14 counts
    wr(18'h01555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'hA0);
    wr(18'h00042, 8'h24);
    chk("R2 bit14 compared", 32'(st), 0);
    wr(18'h05554, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'h90);
    chk("R2 bit0 compared", 32'(id_mode), 0);

    // R10: repeated first step restarts the sequence
    wr(18'h05555, 8'hAA); wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'h90);
    chk("R10 restart on AA", 32'(id_mode), 1);

    // R12: ID map with both lockout values
    for (int lk = 0; lk < 2; lk++) begin
      for (int o = 0; o < 4; o++) begin
        logic [7:0] e;
        lock_state = 1'(lk);
        rd_ofs = 2'(o);
        e = (o == 0) ? 8'hDA : (o == 1) ? 8'h0B : (o == 2) ? 8'(lk) : 8'h00;
        #1;
        chk("R12 id map", 32'(id_rd_data), 32'(e));
      end
    end

    // R7: matching prefix keeps ID mode, R8 prefix exit
    prefix();
    chk("R7 id kept over prefix", 32'(id_mode), 1);
    wr(18'h05555, 8'hF0);
    chk("R8 prefix exit", 32'(id_mode), 0);
    // R8 single-write exit at arbitrary address
    prefix(); wr(18'h05555, 8'h90);
    chk("R7 id re-entry", 32'(id_mode), 1);
    wr(18'h2F0F0, 8'hF0);
    chk("R8 single exit", 32'(id_mode), 0);
    // R9: stray write in ID mode
    prefix(); wr(18'h05555, 8'h90);
    wr(18'h00100, 8'h33);
    chk("R9 stray write clears id", 32'(id_mode), 0);
    // R9: wrong second step aborts
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h54); wr(18'h05555, 8'hA0); wr(18'h00010, 8'h01);
    chk("R9 bad second step", 32'(st), 0);

    // R11: writes during busy are dropped
    prefix();
    busy = 1'b1;
    wr(18'h00000, 8'h00);
    wr(18'h05555, 8'h90);
    chk("R11 id untouched while busy", 32'(id_mode), 0);
    busy = 1'b0;
    wr(18'h05555, 8'hA0);
    wr(18'h00777, 8'h11);
    chk("R11 sequence kept across busy", 32'(st), 1);
    chk("R11 job data", 32'(job_data), 32'h11);
    prefix(); wr(18'h05555, 8'hA0);
    busy = 1'b1;
    wr(18'h00888, 8'h22);
    chk("R11 no start while busy", 32'(st), 0);
    busy = 1'b0;
    wr(18'h00999, 8'h33);
    chk("R11 program after busy", 32'(st), 1);
    chk("R11 job addr after busy", 32'(job_addr), 32'h00999);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R13 watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule